// File: doc/BRIEF.md
# Laser safety fault latch controller

This block decides, once per system clock, whether the laser bias and modulation current drivers may be switched on. It combines the enable bit, an external disable pin and a fault-enable bit with two digital fault indications from analog comparators. It also checks the bias DAC code on its own for a sudden large drop between two consecutive clock cycles.

A qualified fault switches both current drivers off and raises a latched fault flag. The latch clears only after the transmitter has stayed disabled for a programmable number of clock cycles. A disable pulse shorter than that leaves the latch set. After a successful clear, re-enabling the transmitter starts a programmable settling delay before the drivers turn on. If a fault source is still active at re-enable, the flag returns on the next edge and the drivers stay off.

An ordinary disable and re-enable without a fault does not go through the settling delay. The drivers follow the enable immediately, and no stored code is touched.

Top module: `laser_safety_ctrl`

## Requirements
- R1: `bias_on` and `mod_on` are always equal, and both are 1 only while `en_bit`=1 and `dis_pin`=0.
- R2: With no fault latched, the drivers follow `en_bit` and `dis_pin` in the same cycle. Disabling and re-enabling brings them back with no settling delay.
- R3: A step drop is detected when 3 × code < 2 × (code on the previous edge), using integers. A change 90→60 is not a drop. A change 90→59 is a drop. The previous code is 0 after reset.
- R4: With `flt_en`=1, an active `mon_ovr`, `pd_ovr` or step drop seen at a rising edge sets `flt`=1 and turns both drivers off from that edge on.
- R5: With `flt_en`=0, the fault sources have no effect: `flt` stays 0 and the drivers keep following R1.
- R6: The latched fault clears once the transmitter has been disabled (`en_bit`=0 or `dis_pin`=1) at RST_CYC consecutive rising edges. `flt` drops at the last of those edges while the transmitter is still disabled.
- R7: A disable shorter than RST_CYC edges leaves `flt`=1 and the drivers off after re-enable.
- R8: After a clear, the drivers turn on only when the enable has been seen at SETTLE_CYC+1 consecutive edges. Any disable during this time restarts the count.
- R9: If a fault source is active at the first enabled edge after a clear, `flt` returns to 1 from that edge on and the drivers stay off.
- R10: A fault during the settling delay latches the fault, as in R4.
- R11: After reset, `flt`=0 and no fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_bit | input | 1 | Transmitter enable bit from the register file |
| flt_en | input | 1 | Fault detection enable bit |
| dis_pin | input | 1 | External disable input, active high |
| mon_ovr | input | 1 | Bias monitor above threshold |
| pd_ovr | input | 1 | Photodiode current above 150% of target |
| bias_code | input | CODE_W (8) | Current bias DAC code |
| bias_on | output | 1 | Bias current driver enable |
| mod_on | output | 1 | Modulation current driver enable |
| flt | output | 1 | Latched fault flag |

## Verification
The assertions assume that every input is synchronous to `clk` and holds steady between edges. They also assume that the bias code presented at an edge is the value the DAC takes at that edge, so the step-drop check sees each update exactly once. The stimulus changes every input only on the falling clock edge and holds it for whole cycles. It applies bias code changes as single steps with known ratios on either side of the drop threshold. The expected values come from a behavioural model that is advanced on every rising edge and compared with the outputs at every falling edge.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   // sequencer states
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,   // normal operation, drivers follow enable
      ST_FAULT  = 2'd1,   // latched fault, waiting for disable
      ST_CLEAR  = 2'd2,   // disabled, counting toward latch release
      ST_SETTLE = 2'd3    // re-enabled after clear, waiting settle time
   } lsc_state_e;

   function automatic int lsc_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lsc_step_drop.sv
module lsc_step_drop #(
   parameter int CODE_W   = 8,
   parameter int DROP_NUM = 2,   // fault when DEN*new < NUM*old
   parameter int DROP_DEN = 3,
   parameter bit CHECK_ON = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   output logic              drop_o
);
   localparam int MULT_W = $clog2(lsc_pkg::lsc_max(DROP_NUM, DROP_DEN) + 1);
   localparam int PROD_W = CODE_W + MULT_W;

   if (CODE_W < 2) begin : g_bad_w
      $error("lsc_step_drop: CODE_W must be at least 2");
   end
   if (DROP_NUM < 1 || DROP_DEN <= DROP_NUM) begin : g_bad_ratio
      $error("lsc_step_drop: need 0 < DROP_NUM < DROP_DEN");
   end

   if (CHECK_ON) begin : g_check
      logic [CODE_W-1:0] prev_q;
      logic [PROD_W-1:0] new_scaled;
      logic [PROD_W-1:0] old_scaled;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= '0;
         else        prev_q <= code_i;
      end

      always_comb begin
         new_scaled = PROD_W'(code_i) * PROD_W'(DROP_DEN);
         old_scaled = PROD_W'(prev_q) * PROD_W'(DROP_NUM);
         drop_o     = (new_scaled < old_scaled);
      end

      // R3: a drop report always means the code went down
      a_r3_drop_is_decrease: assert property (@(posedge clk) disable iff (!rst_n)
         drop_o |-> (code_i < prev_q));
   end else begin : g_nocheck
      logic unused_ok;
      assign unused_ok = clk ^ rst_n ^ (^code_i);
      assign drop_o    = 1'b0;
   end

endmodule

// File: rtl/lsc_fault_gate.sv
module lsc_fault_gate #(
   parameter int NUM_SRC = 3
) (
   input  logic               flt_en_i,
   input  logic [NUM_SRC-1:0] src_i,
   output logic               fault_o
);
   if (NUM_SRC < 1) begin : g_bad_src
      $error("lsc_fault_gate: NUM_SRC must be at least 1");
   end

   always_comb fault_o = flt_en_i & (|src_i);

endmodule

// File: rtl/lsc_sequencer.sv
module lsc_sequencer #(
   parameter int RST_CYC    = 10,
   parameter int SETTLE_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic fault_i,
   output logic drive_o,
   output logic flt_o
);
   import lsc_pkg::*;

   localparam int MAXC = lsc_max(RST_CYC, SETTLE_CYC);
   localparam int CW   = lsc_max($clog2(MAXC + 1), 1);
   localparam logic [CW-1:0] RST_LOAD = CW'(RST_CYC - 1);
   localparam logic [CW-1:0] SET_LOAD = CW'(SETTLE_CYC - 1);

   if (RST_CYC < 1) begin : g_bad_rst
      $error("lsc_sequencer: RST_CYC must be at least 1");
   end
   if (SETTLE_CYC < 1) begin : g_bad_set
      $error("lsc_sequencer: SETTLE_CYC must be at least 1");
   end

   lsc_state_e    st_q, st_n;
   logic [CW-1:0] cnt_q, cnt_n;

   always_comb begin
      st_n  = st_q;
      cnt_n = cnt_q;
      unique case (st_q)
         ST_RUN: begin
            if (fault_i) st_n = ST_FAULT;
         end
         ST_FAULT: begin
            if (!active_i) begin
               st_n  = ST_CLEAR;
               cnt_n = RST_LOAD;
            end
         end
         ST_CLEAR: begin
            if (active_i) begin
               if (cnt_q != '0)  st_n = ST_FAULT;   // R7: pulse too short
               else if (fault_i) st_n = ST_FAULT;   // R9: fault still there
               else begin
                  st_n  = ST_SETTLE;
                  cnt_n = SET_LOAD;
               end
            end else if (cnt_q != '0) begin
               cnt_n = cnt_q - 1'b1;
            end
         end
         ST_SETTLE: begin
            if (fault_i) st_n = ST_FAULT;            // R10
            else if (!active_i) begin
               st_n  = ST_CLEAR;
               cnt_n = '0;
            end else if (cnt_q == '0) st_n = ST_RUN;
            else cnt_n = cnt_q - 1'b1;
         end
         default: st_n = ST_FAULT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_RUN;
         cnt_q <= '0;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
      end
   end

   always_comb begin
      drive_o = (st_q == ST_RUN) && active_i;
      flt_o   = (st_q == ST_FAULT) || ((st_q == ST_CLEAR) && (cnt_q != '0));
   end

   // R4: a fault in normal operation latches and kills the drivers
   a_r4_fault_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && fault_i) |=> (flt_o && !drive_o));

   // R7: while enabled, a latched flag never clears by itself
   a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_o && active_i) |=> flt_o);

   // R6: the flag only falls after a disabled edge
   a_r6_clear_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flt_o) |-> $past(!active_i));

   // R5: without a fault source, normal operation keeps the flag low
   a_r5_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && !fault_i) |=> !flt_o);

   // R8: drivers only come up through normal operation with enable present
   a_r8_drive_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_o) |-> ($past(st_q) == ST_RUN || $past(st_q) == ST_SETTLE));

endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl #(
   parameter int CODE_W     = 8,
   parameter int RST_CYC    = 10,
   parameter int SETTLE_CYC = 16,
   parameter bit DROP_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_bit,
   input  logic              flt_en,
   input  logic              dis_pin,
   input  logic              mon_ovr,
   input  logic              pd_ovr,
   input  logic [CODE_W-1:0] bias_code,
   output logic              bias_on,
   output logic              mod_on,
   output logic              flt
);
   localparam int NUM_SRC = 3;

   logic               active;
   logic               drop;
   logic               fault_now;
   logic               drive;
   logic [NUM_SRC-1:0] src;

   always_comb active = en_bit & ~dis_pin;
   always_comb src    = {drop, pd_ovr, mon_ovr};

   lsc_step_drop #(
      .CODE_W   (CODE_W),
      .DROP_NUM (2),
      .DROP_DEN (3),
      .CHECK_ON (DROP_CHECK)
   ) u_drop (
      .clk    (clk),
      .rst_n  (rst_n),
      .code_i (bias_code),
      .drop_o (drop)
   );

   lsc_fault_gate #(.NUM_SRC(NUM_SRC)) u_gate (
      .flt_en_i (flt_en),
      .src_i    (src),
      .fault_o  (fault_now)
   );

   lsc_sequencer #(
      .RST_CYC    (RST_CYC),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .fault_i  (fault_now),
      .drive_o  (drive),
      .flt_o    (flt)
   );

   assign bias_on = drive;
   assign mod_on  = drive;

   // R1: drivers never on while disabled by bit or pin
   a_r1_on_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (bias_on || mod_on) |-> (en_bit && !dis_pin));

endmodule

// File: tb/laser_safety_ctrl_test.sv
module laser_safety_ctrl_test;
   localparam int TCLK  = 10;
   localparam int T_RST = 10;
   localparam int T_SET = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_bit = 1'b0, flt_en = 1'b0, dis_pin = 1'b0;
   logic       mon_ovr = 1'b0, pd_ovr = 1'b0;
   logic [7:0] bias_code = 8'd0;
   logic       bias_on, mod_on, flt;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   string cur_req = "R11";

   // model state: 0 normal, 1 latched, 2 cleared but disabled, 3 settling
   int m_mode = 0, m_off = 0, m_set = 0, m_prev = 0;

   always #(TCLK/2) clk = ~clk;

   laser_safety_ctrl uut (
      .clk(clk), .rst_n(rst_n), .en_bit(en_bit), .flt_en(flt_en),
      .dis_pin(dis_pin), .mon_ovr(mon_ovr), .pd_ovr(pd_ovr),
      .bias_code(bias_code), .bias_on(bias_on), .mod_on(mod_on), .flt(flt)
   );

   always @(posedge clk) begin
      bit act, fnow;
      act  = en_bit && !dis_pin;
      fnow = flt_en && (mon_ovr || pd_ovr || (3 * int'(bias_code) < 2 * m_prev));
      if (!rst_n) begin
         m_mode = 0; m_off = 0; m_set = 0; m_prev = 0;
      end else begin
         case (m_mode)
            0: if (fnow) begin m_mode = 1; m_off = 0; end
            1: begin
               if (act) m_off = 0;
               else begin
                  m_off++;
                  if (m_off >= T_RST) m_mode = 2;
               end
            end
            2: if (act) begin
               if (fnow) begin m_mode = 1; m_off = 0; end
               else begin m_mode = 3; m_set = 0; end
            end
            default: begin
               if (fnow) begin m_mode = 1; m_off = 0; end
               else if (!act) m_mode = 2;
               else begin
                  m_set++;
                  if (m_set >= T_SET) m_mode = 0;
               end
            end
         endcase
         m_prev = int'(bias_code);
      end
   end

   task automatic check(input string req, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic compare_model();
      bit exp_on;
      exp_on = (m_mode == 0) && en_bit && !dis_pin;
      check(cur_req, "model bias_on", bias_on, exp_on);
      check(cur_req, "model mod_on", mod_on, exp_on);
      check(cur_req, "model flt", flt, (m_mode == 1));
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         compare_model();
      end
   endtask

   task automatic clear_latch();
      dis_pin = 1'b1; tick(T_RST);
      dis_pin = 1'b0; tick(T_SET + 1);
   endtask

   initial begin
      #(TCLK * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      cur_req = "R11";
      check("R11", "reset flt", flt, 0);
      check("R11", "reset bias_on (disabled)", bias_on, 0);

      cur_req = "R1";
      en_bit = 1'b1; tick(1);
      check("R1", "on when enabled", bias_on, 1);
      dis_pin = 1'b1; tick(1);
      check("R1", "off with pin", bias_on, 0);
      check("R1", "mod off with pin", mod_on, 0);
      cur_req = "R2";
      dis_pin = 1'b0; tick(1);
      check("R2", "back on after pin", bias_on, 1);
      en_bit = 1'b0; tick(1);
      check("R1", "off with bit", mod_on, 0);
      en_bit = 1'b1; tick(1);
      check("R2", "back on after bit", mod_on, 1);

      cur_req = "R5";
      flt_en = 1'b0; mon_ovr = 1'b1; pd_ovr = 1'b1; tick(3);
      check("R5", "flt ignored", flt, 0);
      check("R5", "drive kept", bias_on, 1);
      mon_ovr = 1'b0; pd_ovr = 1'b0;
      bias_code = 8'd200; tick(1);
      bias_code = 8'd10;  tick(2);
      check("R5", "drop ignored", flt, 0);

      cur_req = "R3";
      flt_en = 1'b1;
      bias_code = 8'd90; tick(1);
      bias_code = 8'd60; tick(2);
      check("R3", "90 to 60 no drop", flt, 0);
      bias_code = 8'd90; tick(1);
      bias_code = 8'd59; tick(1);
      check("R3", "90 to 59 drop", flt, 1);
      check("R4", "drop kills drive", bias_on, 0);

      cur_req = "R7";
      dis_pin = 1'b1; tick(T_RST - 1);
      check("R7", "short pulse keeps flt", flt, 1);
      dis_pin = 1'b0; tick(2);
      check("R7", "still latched", flt, 1);
      check("R7", "still off", bias_on, 0);

      cur_req = "R6";
      dis_pin = 1'b1; tick(T_RST);
      check("R6", "flt cleared while disabled", flt, 0);
      tick(2);
      check("R6", "flt stays low", flt, 0);

      cur_req = "R8";
      dis_pin = 1'b0; tick(T_SET);
      check("R8", "still settling", bias_on, 0);
      tick(1);
      check("R8", "on after settle", bias_on, 1);

      cur_req = "R4";
      mon_ovr = 1'b1; tick(1);
      check("R4", "monitor fault flt", flt, 1);
      check("R4", "monitor fault off", mod_on, 0);
      mon_ovr = 1'b0;
      clear_latch();
      check("R8", "recovered", bias_on, 1);

      cur_req = "R9";
      pd_ovr = 1'b1; tick(1);
      check("R4", "pd fault flt", flt, 1);
      en_bit = 1'b0; tick(T_RST);
      check("R6", "cleared by bit", flt, 0);
      en_bit = 1'b1; tick(1);
      check("R9", "flt back at re-enable", flt, 1);
      tick(T_SET + 2);
      check("R9", "no recovery", bias_on, 0);
      pd_ovr = 1'b0;
      clear_latch();
      check("R8", "recovered after pd", bias_on, 1);

      cur_req = "R10";
      mon_ovr = 1'b1; tick(1); mon_ovr = 1'b0;
      dis_pin = 1'b1; tick(T_RST);
      dis_pin = 1'b0; tick(5);
      mon_ovr = 1'b1; tick(1);
      check("R10", "fault in settle", flt, 1);
      mon_ovr = 1'b0;

      cur_req = "R8";
      dis_pin = 1'b1; tick(T_RST);
      dis_pin = 1'b0; tick(5);
      dis_pin = 1'b1; tick(1);
      dis_pin = 1'b0; tick(T_SET);
      check("R8", "restarted settle", bias_on, 0);
      tick(1);
      check("R8", "on after restart", bias_on, 1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule